// File: doc/BRIEF.md
# Coherence Population Monitor

This block watches the coherence state of a single tracked line across a multi-node system. Each node holds that line in one of twelve legal composite states, formed from the state of its private copy and the state of its copy in the shared second-level array. The monitor does not look at cache contents. It keeps one counter per composite state, holding how many nodes currently sit in that state, and updates those counters from transition events that the surrounding protocol logic reports each cycle.

A cycle can carry one node move, or two moves for a synchronized pair of nodes. It can instead carry a bulk invalidate that returns every private-shared-only node to the fully invalid state. The monitor rejects any move whose source population cannot supply the nodes it asks for, and any move that names an unknown state code. It also checks the counters against three cross-state consistency rules. The first problem it finds raises a sticky error flag and is recorded as a cause code. The flag and the code stay until reset.

Top module: `coh_pop_monitor`

## Requirements
- R1: Twelve population counters are exposed on `pop_flat`, counter k at bits [k*CW +: CW]. The state codes are: 0 all-invalid, 1 invalid/shared-shared, 2 invalid/shared-modified, 3 invalid/shared-owned, 4 solo-shared/invalid, 5 shared/invalid, 6 shared/shared, 7 shared/shared-owned, 8 solo-modified/invalid, 9 shared-modified/invalid, 10 owned/invalid, 11 owned/shared-shared.
- R2: While reset is high, counter 0 loads `node_count`, every other counter loads zero, and the error flag and cause clear. Reset is synchronous and active high.
- R3: An accepted single move takes one node out of counter `src` and adds one node to counter `dst` at the next clock edge. A move with equal source and destination leaves the counters unchanged.
- R4: When both move ports are valid, both moves are applied at the same edge. Each source counter must hold at least as many nodes as the moves that name it, so two moves from the same state need a population of two.
- R5: If any source counter is short, the whole cycle is rejected and no counter changes. At that same edge the error flag rises with cause 1 (underflow).
- R6: A valid move with a source or destination code of 12 or above is rejected with no counter change, and raises cause 2 (bad code) at that edge.
- R7: A bulk invalidate adds counters 4 and 5 into counter 0 and clears counters 4 and 5 in one edge. Moves offered in the same cycle are ignored and raise no error.
- R8: The twelve counters always sum to the `node_count` captured at reset.
- R9: If counter 8 or counter 9 is nonzero while counter 11 is nonzero, cause 3 is latched one edge after the counters show it.
- R10: If counter 11 holds two or more nodes, cause 4 is latched one edge after the counters show it.
- R11: If counter 1 is nonzero while counter 7 is nonzero, cause 5 is latched one edge after the counters show it.
- R12: The error flag is sticky and the cause holds the first problem seen. When several are found at one edge, an event cause (1 or 2) beats a state cause, and among state causes the lower code wins. The cause is nonzero exactly when the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_count | input | CW | Number of nodes, loaded into counter 0 during reset |
| ev_a_valid | input | 1 | First move port valid |
| ev_a_src | input | 4 | First move source state code |
| ev_a_dst | input | 4 | First move destination state code |
| ev_b_valid | input | 1 | Second move port valid (paired move when both are valid) |
| ev_b_src | input | 4 | Second move source state code |
| ev_b_dst | input | 4 | Second move destination state code |
| bulk_inv | input | 1 | Bulk invalidate of states 4 and 5 into state 0 |
| pop_flat | output | 12*CW | Packed population counters |
| err_flag | output | 1 | Sticky error flag |
| err_cause | output | 3 | First error cause (0 none) |

## Verification
The assertions assume that `node_count` stays within MAX_NODES and is held steady through reset, because the sum check compares against the value captured at that time. They also assume that any move with an unknown code arrives on a cycle without bulk invalidate when the stable-counter property is meant to apply. The stimulus drives only node counts of seven or fewer and changes them only while reset is high. Illegal codes are sent only in non-bulk cycles, except for one deliberate case that checks a bulk cycle ignores its moves.

// File: rtl/coh_mon_pkg.sv
package coh_mon_pkg;

    localparam int NST = 12;
    localparam int SW  = 4;

    typedef enum logic [SW-1:0] {
        P_INV_S_INV     = 4'd0,
        P_INV_S_SHR     = 4'd1,
        P_INV_S_MOD     = 4'd2,
        P_INV_S_OWN     = 4'd3,
        P_SOLO_S_INV    = 4'd4,
        P_SHR_S_INV     = 4'd5,
        P_SHR_S_SHR     = 4'd6,
        P_SHR_S_OWN     = 4'd7,
        P_MSOLO_S_INV   = 4'd8,
        P_MSHR_S_INV    = 4'd9,
        P_OWN_S_INV     = 4'd10,
        P_OWN_S_SHR     = 4'd11
    } cstate_e;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_UNDERFLOW = 3'd1,
        CAUSE_BADCODE   = 3'd2,
        CAUSE_MOD_OWN   = 3'd3,
        CAUSE_DUP_OWN   = 3'd4,
        CAUSE_SHR_OWN   = 3'd5
    } cause_e;

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] src;
        logic [SW-1:0] dst;
    } move_t;

    function automatic logic code_ok(input logic [SW-1:0] c);
        return c < SW'(NST);
    endfunction

endpackage

// File: rtl/coh_move_check.sv
module coh_move_check
    import coh_mon_pkg::*;
#(
    parameter int CW = 4
) (
    input  move_t                      mv_a,
    input  move_t                      mv_b,
    input  logic                       bulk,
    input  logic [NST-1:0][CW-1:0]     cnt,
    output logic [NST-1:0][1:0]        take,
    output logic [NST-1:0][1:0]        give,
    output logic                       accept,
    output cause_e                     ev_cause
);
    logic bad_code;
    logic short;

    always_comb begin
        bad_code = (mv_a.vld && (!code_ok(mv_a.src) || !code_ok(mv_a.dst))) ||
                   (mv_b.vld && (!code_ok(mv_b.src) || !code_ok(mv_b.dst)));
        short = 1'b0;
        for (int s = 0; s < NST; s++) begin
            take[s] = {1'b0, mv_a.vld && (mv_a.src == SW'(s))} +
                      {1'b0, mv_b.vld && (mv_b.src == SW'(s))};
            give[s] = {1'b0, mv_a.vld && (mv_a.dst == SW'(s))} +
                      {1'b0, mv_b.vld && (mv_b.dst == SW'(s))};
            if (cnt[s] < CW'(take[s]))
                short = 1'b1;
        end
        accept   = 1'b0;
        ev_cause = CAUSE_NONE;
        if (!bulk) begin
            if (bad_code)
                ev_cause = CAUSE_BADCODE;
            else if (short)
                ev_cause = CAUSE_UNDERFLOW;
            else
                accept = mv_a.vld || mv_b.vld;
        end
    end
endmodule

// File: rtl/coh_pop_bank.sv
module coh_pop_bank
    import coh_mon_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CW-1:0]              node_count,
    input  logic                       accept,
    input  logic                       bulk,
    input  logic [NST-1:0][1:0]        take,
    input  logic [NST-1:0][1:0]        give,
    output logic [NST-1:0][CW-1:0]     cnt
);
    logic [NST-1:0][CW-1:0] cnt_d;
    logic [NST-1:0][CW-1:0] cnt_rst;

    for (genvar s = 0; s < NST; s++) begin : g_ctr
        if (s == int'(P_INV_S_INV)) begin : g_home
            assign cnt_rst[s] = node_count;
            assign cnt_d[s] = bulk ? (cnt[s] + cnt[P_SOLO_S_INV] + cnt[P_SHR_S_INV]) :
                              accept ? (cnt[s] - CW'(take[s]) + CW'(give[s])) : cnt[s];
        end else if (s == int'(P_SOLO_S_INV) || s == int'(P_SHR_S_INV)) begin : g_flush
            assign cnt_rst[s] = '0;
            assign cnt_d[s] = bulk ? '0 :
                              accept ? (cnt[s] - CW'(take[s]) + CW'(give[s])) : cnt[s];
        end else begin : g_plain
            assign cnt_rst[s] = '0;
            assign cnt_d[s] = (!bulk && accept) ? (cnt[s] - CW'(take[s]) + CW'(give[s])) : cnt[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= cnt_rst;
        else
            cnt <= cnt_d;
    end
endmodule

// File: rtl/coh_inv_detect.sv
module coh_inv_detect
    import coh_mon_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [NST-1:0][CW-1:0] cnt,
    output cause_e                 inv_cause
);
    logic any_mod;

    always_comb begin
        any_mod = (cnt[P_MSOLO_S_INV] != '0) || (cnt[P_MSHR_S_INV] != '0);
        if (any_mod && cnt[P_OWN_S_SHR] != '0)
            inv_cause = CAUSE_MOD_OWN;
        else if (cnt[P_OWN_S_SHR] > CW'(1))
            inv_cause = CAUSE_DUP_OWN;
        else if (cnt[P_INV_S_SHR] != '0 && cnt[P_SHR_S_OWN] != '0)
            inv_cause = CAUSE_SHR_OWN;
        else
            inv_cause = CAUSE_NONE;
    end
endmodule

// File: rtl/coh_err_latch.sv
module coh_err_latch
    import coh_mon_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_e ev_cause,
    input  cause_e inv_cause,
    output logic   err_flag,
    output cause_e err_cause
);
    cause_e cand;

    always_comb cand = (ev_cause != CAUSE_NONE) ? ev_cause : inv_cause;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag  <= 1'b0;
            err_cause <= CAUSE_NONE;
        end else if (!err_flag && cand != CAUSE_NONE) begin
            err_flag  <= 1'b1;
            err_cause <= cand;
        end
    end
endmodule

// File: rtl/coh_pop_monitor.sv
module coh_pop_monitor
    import coh_mon_pkg::*;
#(
    parameter int MAX_NODES = 8,
    localparam int CW = $clog2(MAX_NODES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CW-1:0]       node_count,
    input  logic                ev_a_valid,
    input  logic [3:0]          ev_a_src,
    input  logic [3:0]          ev_a_dst,
    input  logic                ev_b_valid,
    input  logic [3:0]          ev_b_src,
    input  logic [3:0]          ev_b_dst,
    input  logic                bulk_inv,
    output logic [NST*CW-1:0]   pop_flat,
    output logic                err_flag,
    output logic [2:0]          err_cause
);
    move_t                  mv_a, mv_b;
    logic [NST-1:0][CW-1:0] cnt;
    logic [NST-1:0][1:0]    take, give;
    logic                   accept;
    cause_e                 ev_cause, inv_cause, cause_q;

    assign mv_a = '{vld: ev_a_valid, src: ev_a_src, dst: ev_a_dst};
    assign mv_b = '{vld: ev_b_valid, src: ev_b_src, dst: ev_b_dst};

    coh_move_check #(.CW(CW)) move_i (
        .mv_a(mv_a), .mv_b(mv_b), .bulk(bulk_inv), .cnt(cnt),
        .take(take), .give(give), .accept(accept), .ev_cause(ev_cause)
    );

    coh_pop_bank #(.CW(CW)) bank_i (
        .clk(clk), .rst(rst), .node_count(node_count), .accept(accept),
        .bulk(bulk_inv), .take(take), .give(give), .cnt(cnt)
    );

    coh_inv_detect #(.CW(CW)) inv_i (
        .cnt(cnt), .inv_cause(inv_cause)
    );

    coh_err_latch err_i (
        .clk(clk), .rst(rst), .ev_cause(ev_cause), .inv_cause(inv_cause),
        .err_flag(err_flag), .err_cause(cause_q)
    );

    assign pop_flat  = cnt;
    assign err_cause = cause_q;
endmodule

// File: rtl/coh_pop_monitor_chk.sv
module coh_pop_monitor_chk
    import coh_mon_pkg::*;
#(
    parameter int CW = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [CW-1:0]     node_count,
    input logic              ev_a_valid,
    input logic [3:0]        ev_a_src,
    input logic [3:0]        ev_a_dst,
    input logic              bulk_inv,
    input logic [NST*CW-1:0] pop_flat,
    input logic              err_flag,
    input logic [2:0]        err_cause
);
    logic [CW-1:0]   held_nc;
    logic [CW+3:0]   pop_sum;
    logic            others_zero;

    always_ff @(posedge clk) begin
        if (rst) held_nc <= node_count;
    end

    always_comb begin
        pop_sum = '0;
        others_zero = 1'b1;
        for (int s = 0; s < NST; s++) begin
            pop_sum = pop_sum + (CW+4)'(pop_flat[s*CW +: CW]);
            if (s != 0 && pop_flat[s*CW +: CW] != '0) others_zero = 1'b0;
        end
    end

    // R2
    reset_load_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pop_flat[CW-1:0] == held_nc) && others_zero && !err_flag);

    // R8
    pop_sum_chk: assert property (@(posedge clk) disable iff (rst)
        pop_sum == (CW+4)'(held_nc));

    // R6
    bad_code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_a_valid && !bulk_inv && (ev_a_src >= 4'(NST) || ev_a_dst >= 4'(NST)))
        |=> $stable(pop_flat));

    // R7
    bulk_clear_chk: assert property (@(posedge clk) disable iff (rst)
        bulk_inv |=> (pop_flat[4*CW +: CW] == '0) && (pop_flat[5*CW +: CW] == '0));

    // R12
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag && $stable(err_cause));

    // R12
    cause_match_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag == (err_cause != 3'd0));
endmodule

bind coh_pop_monitor coh_pop_monitor_chk #(.CW(CW)) chk_i (
    .clk(clk), .rst(rst), .node_count(node_count), .ev_a_valid(ev_a_valid),
    .ev_a_src(ev_a_src), .ev_a_dst(ev_a_dst), .bulk_inv(bulk_inv),
    .pop_flat(pop_flat), .err_flag(err_flag), .err_cause(err_cause)
);

// File: tb/coh_pop_monitor_tb_top.sv
module coh_pop_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXN = 8;
    localparam int CW = $clog2(MAXN + 1);
    localparam int NS = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] node_count = CW'(4);
    logic          ev_a_valid = 1'b0, ev_b_valid = 1'b0, bulk_inv = 1'b0;
    logic [3:0]    ev_a_src = '0, ev_a_dst = '0, ev_b_src = '0, ev_b_dst = '0;
    logic [NS*CW-1:0] pop_flat;
    logic          err_flag;
    logic [2:0]    err_cause;

    int n_checks = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_pop_monitor #(.MAX_NODES(MAXN)) dut_i (
        .clk(clk), .rst(rst), .node_count(node_count),
        .ev_a_valid(ev_a_valid), .ev_a_src(ev_a_src), .ev_a_dst(ev_a_dst),
        .ev_b_valid(ev_b_valid), .ev_b_src(ev_b_src), .ev_b_dst(ev_b_dst),
        .bulk_inv(bulk_inv), .pop_flat(pop_flat),
        .err_flag(err_flag), .err_cause(err_cause)
    );

    typedef struct packed {
        logic av; logic [3:0] as_; logic [3:0] ad;
        logic bv; logic [3:0] bs;  logic [3:0] bd;
        logic bk; logic [3:0] ci;  logic [3:0] cv;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b1, 4'd0,  4'd4,  1'b0, 4'd0, 4'd0, 1'b0, 4'd4,  4'd1},
        '{1'b1, 4'd4,  4'd5,  1'b1, 4'd0, 4'd5, 1'b0, 4'd5,  4'd2},
        '{1'b1, 4'd0,  4'd8,  1'b0, 4'd0, 4'd0, 1'b0, 4'd0,  4'd1},
        '{1'b1, 4'd8,  4'd10, 1'b1, 4'd0, 4'd5, 1'b0, 4'd5,  4'd3},
        '{1'b1, 4'd10, 4'd0,  1'b0, 4'd0, 4'd0, 1'b1, 4'd0,  4'd3},
        '{1'b1, 4'd10, 4'd10, 1'b0, 4'd0, 4'd0, 1'b0, 4'd10, 4'd1},
        '{1'b1, 4'd0,  4'd1,  1'b0, 4'd0, 4'd0, 1'b0, 4'd1,  4'd1},
        '{1'b1, 4'd0,  4'd6,  1'b1, 4'd0, 4'd6, 1'b0, 4'd6,  4'd2},
        '{1'b1, 4'd6,  4'd11, 1'b0, 4'd0, 4'd0, 1'b0, 4'd11, 4'd1},
        '{1'b0, 4'd0,  4'd0,  1'b0, 4'd0, 4'd0, 1'b0, 4'd6,  4'd1}
    };

    function automatic int pop(input int idx);
        return int'(pop_flat[idx*CW +: CW]);
    endfunction

    function automatic int pop_total();
        int t = 0;
        for (int s = 0; s < NS; s++) t += pop(s);
        return t;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic av, input logic [3:0] as_, input logic [3:0] ad,
                         input logic bv, input logic [3:0] bs, input logic [3:0] bd,
                         input logic bk);
        @(negedge clk);
        ev_a_valid = av; ev_a_src = as_; ev_a_dst = ad;
        ev_b_valid = bv; ev_b_src = bs;  ev_b_dst = bd;
        bulk_inv = bk;
        @(posedge clk);
        #1;
        ev_a_valid = 1'b0; ev_b_valid = 1'b0; bulk_inv = 1'b0;
    endtask

    task automatic idle_cycle();
        drive(1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0, 1'b0);
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        node_count = CW'(n);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R2 reset state with 4 nodes
        do_reset(4);
        check("R2 counter0", pop(0), 4);
        for (int s = 1; s < NS; s++) check("R2 other counter", pop(s), 0);
        check("R2 err_flag", int'(err_flag), 0);
        check("R2 err_cause", int'(err_cause), 0);

        // R1 R3 R4 R7 R8: vector walk
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i].av, VEC[i].as_, VEC[i].ad, VEC[i].bv, VEC[i].bs, VEC[i].bd, VEC[i].bk);
            check("R1 R3 R4 R7 vector counter", pop(int'(VEC[i].ci)), int'(VEC[i].cv));
            check("R8 population sum", pop_total(), 4);
            check("R7 R3 no error in legal walk", int'(err_flag), 0);
        end

        // R2 different node count
        do_reset(7);
        check("R2 counter0 seven", pop(0), 7);

        // R5 underflow single
        do_reset(3);
        drive(1'b1, 4'd4, 4'd0, 1'b0, 4'd0, 4'd0, 1'b0);
        check("R5 underflow flag", int'(err_flag), 1);
        check("R5 underflow cause", int'(err_cause), 1);
        check("R5 counter0 unchanged", pop(0), 3);
        check("R5 counter4 unchanged", pop(4), 0);

        // R4 R5 pair from same source, population one
        do_reset(1);
        drive(1'b1, 4'd0, 4'd4, 1'b1, 4'd0, 4'd5, 1'b0);
        check("R4 pair short cause", int'(err_cause), 1);
        check("R4 pair short counter0", pop(0), 1);
        check("R4 pair short counter5", pop(5), 0);

        // R6 bad code
        do_reset(3);
        drive(1'b1, 4'd13, 4'd0, 1'b0, 4'd0, 4'd0, 1'b0);
        check("R6 badcode cause", int'(err_cause), 2);
        check("R6 badcode counter0", pop(0), 3);

        // R7 bulk ignores a bad move
        do_reset(3);
        drive(1'b1, 4'd0, 4'd4, 1'b0, 4'd0, 4'd0, 1'b0);
        drive(1'b1, 4'd15, 4'd0, 1'b0, 4'd0, 4'd0, 1'b1);
        check("R7 bulk counter0", pop(0), 3);
        check("R7 bulk counter4", pop(4), 0);
        check("R7 bulk ignores move error", int'(err_flag), 0);

        // R9 modified with owner-shared, latched one edge later
        do_reset(3);
        drive(1'b1, 4'd0, 4'd8, 1'b0, 4'd0, 4'd0, 1'b0);
        drive(1'b1, 4'd0, 4'd11, 1'b0, 4'd0, 4'd0, 1'b0);
        check("R9 not yet latched", int'(err_flag), 0);
        idle_cycle();
        check("R9 cause", int'(err_cause), 3);
        // R12 sticky, first cause kept
        drive(1'b1, 4'd14, 4'd0, 1'b0, 4'd0, 4'd0, 1'b0);
        check("R12 first cause kept", int'(err_cause), 3);
        check("R12 flag sticky", int'(err_flag), 1);

        // R10 two owner-shared nodes
        do_reset(3);
        drive(1'b1, 4'd0, 4'd11, 1'b1, 4'd0, 4'd11, 1'b0);
        idle_cycle();
        check("R10 cause", int'(err_cause), 4);

        // R11 shared-shared with shared-owned
        do_reset(3);
        drive(1'b1, 4'd0, 4'd1, 1'b1, 4'd0, 4'd7, 1'b0);
        idle_cycle();
        check("R11 cause", int'(err_cause), 5);

        // R12 event cause beats state cause at the same edge
        do_reset(3);
        drive(1'b1, 4'd0, 4'd11, 1'b1, 4'd0, 4'd11, 1'b0);
        drive(1'b1, 4'd14, 4'd0, 1'b0, 4'd0, 4'd0, 1'b0);
        check("R12 event priority", int'(err_cause), 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule